// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a bank of small memory-mapped control registers for a workstation I/O controller. A simple register bus selects one of eight registers by address. It carries a write strobe, an access size (byte, halfword or word) and 32-bit write data. Reads return data combinationally. The bank holds a configuration byte, a diagnostic byte, a modem-control byte, a 16-bit LED word, a 32-bit system-control word, two auxiliary registers and a write-only power-management port.

The block watches an external power-fail input. When the configuration register enables the power interrupt, a change on that input latches a status bit in the second auxiliary register. That status, gated by the enable, drives a registered level interrupt. Writes to the auxiliary and system registers produce several requests: a one-cycle floppy terminal-count pulse, a sticky power-off request, a one-cycle system reset request and a sticky CPU-halt request.

The register index is taken from three address bits starting at bit `SEL_LSB`. Any address with other bits set is unmapped. The indices are: 0 configuration, 1 diagnostic, 2 modem control, 3 LED, 4 system control, 5 aux1, 6 aux2, 7 power management. Access size encoding: 2'b00 byte, 2'b01 halfword, 2'b10 word.

Top module: `auxctl_regs`

## Requirements
- R1: `irq_o` is high exactly when the aux2 power-fail status (aux2 read bit 5) and the configuration enable (config bit 3) are both set, one clock cycle after the later of the two.
- R2: On each change of the (synchronized) power-fail input, the status is set if the input is now high and config bit 3 is set. Otherwise it is cleared. Without an input change, the status holds.
- R3: An aux2 write stores only bits 1:0. Bit 5 of an aux2 read always shows the status, so a write can never set it. A write with bit 1 set clears the status.
- R4: An aux2 write with bit 0 set raises `pwr_off_o`, which stays high until reset.
- R5: An aux1 write with bit `TC_BIT` (default 1) set gives a one-cycle pulse on `fd_tc_o` in the cycle after the write. That bit is stored as 0, and all other bits of the byte are stored.
- R6: A word-size write to system control with bit 0 set loads 0x00000002 and pulses `sys_rst_req_o` for one cycle. A word write with bit 0 clear stores the written value. A non-word write is ignored.
- R7: Reset clears config, aux1, aux2, modem control, `cpu_halt_o`, `pwr_off_o` and `irq_o`. The diagnostic, LED and system-control registers keep their values.
- R8: Config, diagnostic and modem control store the low byte of a write of any size. LED stores the low 16 bits of a halfword write only.
- R9: Any write to index 7 raises `cpu_halt_o` until reset. Reads of index 7 return 0.
- R10: An address with any bit outside the index field set is unmapped. Reads there return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| pwr_fail_i | input | 1 | External power-fail level |
| irq_o | output | 1 | Power-fail interrupt level |
| fd_tc_o | output | 1 | Floppy terminal-count pulse |
| pwr_off_o | output | 1 | Sticky power-off request |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| cpu_halt_o | output | 1 | Sticky CPU-halt request |

## Verification
The bench builds the block with `PF_SYNC_STAGES` = 0 and leaves the other parameters at their defaults: `ADDR_W` = 8, `SEL_LSB` = 2, `TC_BIT` = 1. With no synchronizer stages, a power-fail edge reaches the status bit at the next clock edge and the interrupt one edge later. This makes the exact cycle of R1 and R2 observable. The address 0x20 sits just above the index field, so the bench can test unmapped decode. It can also drive size mismatches on the LED and system registers.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;
   typedef enum logic [2:0] {
      IDX_CFG  = 3'd0,
      IDX_DIAG = 3'd1,
      IDX_MDM  = 3'd2,
      IDX_LED  = 3'd3,
      IDX_SYS  = 3'd4,
      IDX_AUX1 = 3'd5,
      IDX_AUX2 = 3'd6,
      IDX_PM   = 3'd7
   } reg_idx_e;

   localparam int unsigned NUM_REGS = 8;
   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;
   localparam int unsigned CFG_EN_BIT  = 3;
   localparam int unsigned AUX2_PF_BIT = 5;
   localparam logic [31:0] SYS_RST_STATUS = 32'h0000_0002;
endpackage

// File: rtl/auxctl_decode.sv
module auxctl_decode #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned SEL_LSB = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   output logic              hit_o,
   output logic [2:0]        idx_o,
   output logic [7:0]        we_o
);
   localparam int unsigned TOP_LSB = SEL_LSB + 3;

   if (SEL_LSB < 1) begin : g_bad_lsb
      $error("SEL_LSB must be at least 1");
   end
   if (ADDR_W <= TOP_LSB) begin : g_bad_width
      $error("ADDR_W must exceed SEL_LSB + 3");
   end

   always_comb begin
      hit_o = (addr_i[ADDR_W-1:TOP_LSB] == '0) && (addr_i[SEL_LSB-1:0] == '0);
      idx_o = addr_i[TOP_LSB-1:SEL_LSB];
      we_o  = (hit_o && wr_i) ? (8'b1 << idx_o) : 8'b0;
   end
endmodule

// File: rtl/auxctl_pfsync.sv
module auxctl_pfsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sh_q <= '0;
         else         sh_q <= {sh_q[STAGES-2+1-1:0], d_i} >> 0;
      end
      assign q_o = sh_q[STAGES-1];
   end
endmodule

// File: rtl/auxctl_pwrfail.sv
module auxctl_pwrfail (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pf_i,
   input  logic en_i,
   input  logic clr_i,
   output logic status_o,
   output logic irq_o
);
   logic prev_q, st_q, irq_q;
   logic chg;

   assign chg = pf_i ^ prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         st_q   <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         prev_q <= pf_i;
         if (clr_i)    st_q <= 1'b0;
         else if (chg) st_q <= pf_i & en_i;
         irq_q <= st_q & en_i;
      end
   end

   assign status_o = st_q;
   assign irq_o    = irq_q;

   // R3: no path other than an input change may set the status
   assert_status_not_set_by_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!st_q && !chg) |=> !st_q);
   // R2: an input change with the enable clear leaves the status clear
   assert_status_needs_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chg && !en_i) |=> !st_q);
endmodule

// File: rtl/auxctl_regs.sv
module auxctl_regs
   import auxctl_pkg::*;
#(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned SEL_LSB        = 2,
   parameter int unsigned TC_BIT         = 1,
   parameter int unsigned PF_SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [1:0]        bus_size_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic              pwr_fail_i,
   output logic              irq_o,
   output logic              fd_tc_o,
   output logic              pwr_off_o,
   output logic              sys_rst_req_o,
   output logic              cpu_halt_o
);
   localparam logic [7:0] TC_MASK = 8'(1) << TC_BIT;

   if (TC_BIT > 7) begin : g_bad_tc
      $error("TC_BIT must address a bit of the aux1 byte");
   end

   logic       hit;
   logic [2:0] idx;
   logic [7:0] we;
   logic       pf_sync, pf_status, aux2_clr;

   logic [7:0]  cfg_q, aux1_q, mdm_q, diag_q;
   logic [1:0]  aux2_q;
   logic [15:0] led_q;
   logic [31:0] sys_q;
   logic        tc_q, rstreq_q, halt_q, off_q;

   auxctl_decode #(.ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB)) i_decode (
      .addr_i(bus_addr_i), .wr_i(bus_wr_i),
      .hit_o(hit), .idx_o(idx), .we_o(we)
   );

   auxctl_pfsync #(.STAGES(PF_SYNC_STAGES)) i_pfsync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_fail_i), .q_o(pf_sync)
   );

   assign aux2_clr = we[IDX_AUX2] & bus_wdata_i[1];

   auxctl_pwrfail i_pwrfail (
      .clk_i(clk_i), .rst_ni(rst_ni), .pf_i(pf_sync),
      .en_i(cfg_q[CFG_EN_BIT]), .clr_i(aux2_clr),
      .status_o(pf_status), .irq_o(irq_o)
   );

   // registers cleared by reset
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q    <= '0;
         aux1_q   <= '0;
         aux2_q   <= '0;
         mdm_q    <= '0;
         tc_q     <= 1'b0;
         rstreq_q <= 1'b0;
         halt_q   <= 1'b0;
         off_q    <= 1'b0;
      end else begin
         tc_q     <= 1'b0;
         rstreq_q <= 1'b0;
         if (we[IDX_CFG]) cfg_q <= bus_wdata_i[7:0];
         if (we[IDX_MDM]) mdm_q <= bus_wdata_i[7:0];
         if (we[IDX_AUX1]) begin
            aux1_q <= bus_wdata_i[7:0] & ~TC_MASK;
            tc_q   <= bus_wdata_i[TC_BIT];
         end
         if (we[IDX_AUX2]) begin
            aux2_q <= bus_wdata_i[1:0];
            if (bus_wdata_i[0]) off_q <= 1'b1;
         end
         if (we[IDX_PM]) halt_q <= 1'b1;
         if (we[IDX_SYS] && bus_size_i == SZ_WORD && bus_wdata_i[0]) rstreq_q <= 1'b1;
      end
   end

   // registers kept across reset
   always_ff @(posedge clk_i) begin
      if (we[IDX_DIAG]) diag_q <= bus_wdata_i[7:0];
      if (we[IDX_LED] && bus_size_i == SZ_HALF) led_q <= bus_wdata_i[15:0];
      if (we[IDX_SYS] && bus_size_i == SZ_WORD)
         sys_q <= bus_wdata_i[0] ? SYS_RST_STATUS : bus_wdata_i;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (hit) begin
         unique case (reg_idx_e'(idx))
            IDX_CFG:  bus_rdata_o = {24'b0, cfg_q};
            IDX_DIAG: bus_rdata_o = {24'b0, diag_q};
            IDX_MDM:  bus_rdata_o = {24'b0, mdm_q};
            IDX_LED:  bus_rdata_o = {16'b0, led_q};
            IDX_SYS:  bus_rdata_o = sys_q;
            IDX_AUX1: bus_rdata_o = {24'b0, aux1_q};
            IDX_AUX2: bus_rdata_o = {26'b0, pf_status, 3'b0, aux2_q};
            IDX_PM:   bus_rdata_o = '0;
         endcase
      end
   end

   assign fd_tc_o       = tc_q;
   assign sys_rst_req_o = rstreq_q;
   assign cpu_halt_o    = halt_q;
   assign pwr_off_o     = off_q;

   assert_irq_needs_enable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> $past(cfg_q[CFG_EN_BIT]));
   assert_pwroff_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_off_o |=> pwr_off_o);
   assert_tc_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fd_tc_o |-> $past(we[IDX_AUX1] && bus_wdata_i[TC_BIT]));
   assert_tc_not_stored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !aux1_q[TC_BIT]);
   assert_rstreq_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sys_rst_req_o |-> (sys_q == SYS_RST_STATUS));
   assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_halt_o |=> cpu_halt_o);
endmodule

// File: tb/test_auxctl_regs.sv
module test_auxctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [1:0]  size = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pf = 1'b0;
   logic        irq, tc, off, rreq, halt;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   auxctl_regs #(.PF_SYNC_STAGES(0)) i_auxctl_regs (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_size_i(size), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .pwr_fail_i(pf), .irq_o(irq), .fd_tc_o(tc), .pwr_off_o(off),
      .sys_rst_req_o(rreq), .cpu_halt_o(halt)
   );

   typedef struct packed {
      logic [7:0]  a;
      logic [1:0]  s;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{8'h00, 2'b00, 32'h0000_01A5, 32'h0000_00A5},  // R8 cfg low byte
      '{8'h04, 2'b10, 32'h1234_563C, 32'h0000_003C},  // R8 diag
      '{8'h08, 2'b01, 32'h0000_00FF, 32'h0000_00FF},  // R8 modem
      '{8'h0C, 2'b01, 32'h1234_ABCD, 32'h0000_ABCD},  // R8 led halfword
      '{8'h0C, 2'b00, 32'h0000_0055, 32'h0000_ABCD},  // R8 led byte ignored
      '{8'h10, 2'b10, 32'h0000_0080, 32'h0000_0080},  // R6 sys word store
      '{8'h10, 2'b01, 32'h0000_0041, 32'h0000_0080},  // R6 sys halfword ignored
      '{8'h14, 2'b00, 32'h0000_00F0, 32'h0000_00F0},  // R5 aux1 store
      '{8'h14, 2'b00, 32'h0000_000F, 32'h0000_000D},  // R5 tc bit dropped
      '{8'h20, 2'b10, 32'h0000_FFFF, 32'h0000_0000},  // R10 unmapped
      '{8'h00, 2'b00, 32'h0000_0000, 32'h0000_0000}   // R8 cfg cleared
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      addr = a; size = s; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      addr = a; wr = 1'b0;
      #1;
      d = rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
         finish_run();
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state
      bus_read(8'h00, r); check("R7 cfg after reset", r, 32'h0);
      bus_read(8'h18, r); check("R7 aux2 after reset", r, 32'h0);
      check("R7 halt/off/irq after reset", {29'b0, halt, off, irq}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         bus_write(VEC[i].a, VEC[i].s, VEC[i].d);
         bus_read(VEC[i].a, r);
         check($sformatf("R8/R5/R6/R10 vector %0d", i), r, VEC[i].e);
      end

      // R5 terminal-count pulse is one cycle long
      @(negedge clk);
      addr = 8'h14; size = 2'b00; wdata = 32'h02; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      check("R5 tc pulse high", {31'b0, tc}, 32'h1);
      @(negedge clk);
      check("R5 tc pulse ends", {31'b0, tc}, 32'h0);

      // R1/R2: enable then power fail
      bus_write(8'h00, 2'b00, 32'h08);
      pf = 1'b1;
      @(negedge clk);
      check("R1 irq not yet", {31'b0, irq}, 32'h0);
      bus_read(8'h18, r); check("R2 status set", r, 32'h20);
      @(negedge clk);
      check("R1 irq raised", {31'b0, irq}, 32'h1);

      // R1: enable off masks irq while status stays
      bus_write(8'h00, 2'b00, 32'h00);
      @(negedge clk);
      check("R1 irq masked", {31'b0, irq}, 32'h0);
      bus_read(8'h18, r); check("R1 status kept", r, 32'h20);
      bus_write(8'h00, 2'b00, 32'h08);
      @(negedge clk);
      check("R1 irq back", {31'b0, irq}, 32'h1);

      // R3: aux2 write without clear keeps status; clear bit drops it
      bus_write(8'h18, 2'b00, 32'hFC);
      bus_read(8'h18, r); check("R3 status kept, low bits stored", r, 32'h20);
      bus_write(8'h18, 2'b00, 32'h02);
      bus_read(8'h18, r); check("R3 clear bit", r, 32'h02);
      @(negedge clk);
      check("R1 irq after clear", {31'b0, irq}, 32'h0);

      // R3: software cannot set the status bit
      pf = 1'b0;
      @(negedge clk);
      bus_write(8'h18, 2'b00, 32'h20);
      bus_read(8'h18, r); check("R3 write cannot set status", r, 32'h00);

      // R2: input edge with enable clear leaves status clear
      bus_write(8'h00, 2'b00, 32'h00);
      pf = 1'b1;
      @(negedge clk); @(negedge clk);
      bus_read(8'h18, r); check("R2 no status without enable", r, 32'h00);
      check("R2 no irq without enable", {31'b0, irq}, 32'h0);
      pf = 1'b0;
      @(negedge clk);

      // R4 power off sticky
      check("R4 off idle", {31'b0, off}, 32'h0);
      bus_write(8'h18, 2'b00, 32'h01);
      check("R4 off set", {31'b0, off}, 32'h1);
      bus_write(8'h18, 2'b00, 32'h00);
      check("R4 off sticky", {31'b0, off}, 32'h1);

      // R6 reset request
      @(negedge clk);
      addr = 8'h10; size = 2'b10; wdata = 32'hF1; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      check("R6 reset req pulse", {31'b0, rreq}, 32'h1);
      bus_read(8'h10, r); check("R6 status value", r, 32'h2);
      @(negedge clk);
      check("R6 reset req ends", {31'b0, rreq}, 32'h0);

      // R9 halt
      check("R9 halt idle", {31'b0, halt}, 32'h0);
      bus_write(8'h1C, 2'b00, 32'h0);
      check("R9 halt set", {31'b0, halt}, 32'h1);
      bus_read(8'h1C, r); check("R9 pm reads zero", r, 32'h0);

      // R10 unmapped write changes nothing
      bus_write(8'h21, 2'b00, 32'h5A);
      bus_read(8'h00, r); check("R10 cfg untouched", r, 32'h0);

      // R7 reset keeps diag, led, sys
      bus_write(8'h04, 2'b00, 32'h77);
      bus_write(8'h10, 2'b10, 32'h44);
      bus_write(8'h00, 2'b00, 32'h08);
      bus_write(8'h14, 2'b00, 32'h40);
      bus_write(8'h08, 2'b00, 32'h11);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(8'h00, r); check("R7 cfg cleared", r, 32'h0);
      bus_read(8'h14, r); check("R7 aux1 cleared", r, 32'h0);
      bus_read(8'h08, r); check("R7 modem cleared", r, 32'h0);
      bus_read(8'h18, r); check("R7 aux2 cleared", r, 32'h0);
      bus_read(8'h04, r); check("R7 diag kept", r, 32'h77);
      bus_read(8'h10, r); check("R7 sys kept", r, 32'h44);
      bus_read(8'h0C, r); check("R7 led kept", r, 32'hABCD);
      check("R7 halt/off cleared", {30'b0, halt, off}, 32'h0);

      finish_run();
   end
endmodule